// File: doc/BRIEF.md
# Extended Program Bank Page Mapper

The block translates a CPU address in the upper half of the 16-bit address space (0x8000–0xFFFF) into a physical program-memory address. It does this by looking up a page number for one of four 8 KB windows. Each page number is built in three steps. An outer block base is formed from two configuration registers. A per-window bank value is then masked by an inner mask whose width comes from a 3-bit mode field. Finally the masked bank value is ORed onto the base.

Configuration arrives as CPU writes. A sixteen-entry extended register file is written at 0x4100–0x410F. A command/data pair, compatible with the common bank-switching scheme, is decoded in the 0x8000–0x9FFF range. It can reload the two selectable window registers and flip the first and third windows.

A static strap input exchanges the sources of the first two windows. This covers boards whose software programs the two selectable registers in the opposite order.

Top module: `prg_page_mapper`

## Requirements
- R1: Reset clears all sixteen extended registers. Afterwards the pages read 0x000, 0x000, 0x03E and 0x03F for the windows at 0x8000, 0xA000, 0xC000 and 0xE000.
- R2: The inner mask is 0xFF when extended register 11 bits 2:0 equal 7. For any other mode value m it is 0x3F shifted right by m.
- R3: The block base is extended register 0 bits 7:4 placed at page bits 11:8, plus extended register 10 ANDed with the inverted mask. Each window page is the base ORed with (bank value AND mask).
- R4: The bank values are assigned as follows. Window 0 uses register 7 and window 1 uses register 8. Window 2 uses register 9 when register 11 bit 6 is 1, and the constant 0xFE otherwise. Window 3 always uses 0xFF.
- R5: When command register (extended register 5) bit 6 is 1, the pages for 0x8000 and 0xC000 are exchanged. The pages for 0xA000 and 0xE000 do not change.
- R6: A write with (address AND 0xE001) equal to 0x8000 replaces command bits 7:6 and 2:0 with the data bits. Command bits 5:3 keep their value.
- R7: A write with (address AND 0xE001) equal to 0x8001 loads register 7 when command bits 2:0 are 6, and register 8 when they are 7. Any other command index leaves every program page unchanged, and so does any write at 0xA000–0xFFFF.
- R8: When swapStrap is 1, window 0 takes register 8 and window 1 takes register 7.
- R9: A write at 0x4100–0x410F stores the full data byte into extended register (address bits 3:0). Writes at other addresses in the 0x4000 page, such as 0x4110 or 0x4007, change no register.
- R10: physAddr is {page, cpuAddr[12:0]}, with the window selected by cpuAddr[14:13]. inWindow equals cpuAddr[15].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWe | input | 1 | Write strobe, sampled on the rising clock edge |
| swapStrap | input | 1 | Static strap that exchanges the sources of windows 0 and 1 |
| physAddr | output | 25 | Physical page (12 bits) concatenated with cpuAddr[12:0] |
| inWindow | output | 1 | The address lies in 0x8000–0xFFFF |

## Verification
Several properties are checked on every cycle. At most one write target is active at a time. The command write preserves the middle command bits. A banked data write lands in the register named by the command index. The low address bits pass through unchanged. The last window always shows all mask bits set.

Other behaviour can only be shown by the bench's scenarios, because it depends on sequences of writes with known values. This covers the exact page arithmetic for each mode, the block base composition, the 0x8000/0xC000 exchange, the strap, the ignored command indices and the decode boundaries of the extended register range.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int IDX_BASE = 0;
  localparam int IDX_CMD  = 5;
  localparam int IDX_WIN0 = 7;
  localparam int IDX_WIN1 = 8;
  localparam int IDX_WIN2 = 9;
  localparam int IDX_INNR = 10;
  localparam int IDX_MODE = 11;

  typedef struct packed {
    logic       xregWe;
    logic [3:0] xregIdx;
    logic       cmdWe;
    logic       bankWe;
    logic       bankSel;   // 0: register 7, 1: register 8
  } wrStrobe_t;
endpackage

// File: rtl/prg_map_ctrl.sv
module prg_map_ctrl
  import prg_map_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [2:0]        cmdIdx,
  output wrStrobe_t         strobe
);
  logic [ADDR_W-1:0] cmdDecode;
  logic              hitXreg;
  logic              hitCmd;
  logic              hitData;

  always_comb begin
    cmdDecode = cpuAddr & ADDR_W'(16'hE001);
    hitXreg   = (cpuAddr[ADDR_W-1:4] == (ADDR_W-4)'(12'h410));
    hitCmd    = (cmdDecode == ADDR_W'(16'h8000));
    hitData   = (cmdDecode == ADDR_W'(16'h8001));
    strobe.xregWe  = cpuWe && hitXreg;
    strobe.xregIdx = cpuAddr[3:0];
    strobe.cmdWe   = cpuWe && hitCmd;
    strobe.bankWe  = cpuWe && hitData && (cmdIdx[2:1] == 2'b11);
    strobe.bankSel = cmdIdx[0];
  end

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.xregWe, strobe.cmdWe, strobe.bankWe}));
endmodule

// File: rtl/prg_map_dp.sv
module prg_map_dp
  import prg_map_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 12,
  parameter int OFF_W    = 13,
  parameter int NUM_XREG = 16,
  parameter int NUM_WIN  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  wrStrobe_t                strobe,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [DATA_W-1:0]        cpuData,
  input  logic                     swapStrap,
  output logic [2:0]               cmdIdx,
  output logic [PAGE_W+OFF_W-1:0]  physAddr,
  output logic                     inWindow
);
  localparam int SEL_W = $clog2(NUM_WIN);

  logic [DATA_W-1:0] xreg [NUM_XREG];
  logic [2:0]        mode;
  logic [DATA_W-1:0] mask;
  logic [PAGE_W-1:0] base;
  logic [DATA_W-1:0] bankVal [NUM_WIN];
  logic [PAGE_W-1:0] winPage [NUM_WIN];
  logic [SEL_W-1:0]  slot;
  logic [SEL_W-1:0]  effSlot;
  logic [PAGE_W-1:0] pageOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_XREG; i++) xreg[i] <= '0;
    end else if (strobe.xregWe) begin
      xreg[strobe.xregIdx] <= cpuData;
    end else if (strobe.cmdWe) begin
      xreg[IDX_CMD] <= (xreg[IDX_CMD] & DATA_W'(8'h38)) | (cpuData & DATA_W'(8'hC7));
    end else if (strobe.bankWe) begin
      if (strobe.bankSel) xreg[IDX_WIN1] <= cpuData;
      else                xreg[IDX_WIN0] <= cpuData;
    end
  end

  assign cmdIdx = xreg[IDX_CMD][2:0];

  always_comb begin
    mode = xreg[IDX_MODE][2:0];
    mask = (mode == 3'd7) ? DATA_W'(8'hFF) : (DATA_W'(8'h3F) >> mode);
    base = PAGE_W'({xreg[IDX_BASE][7:4], 8'h00}) + PAGE_W'(xreg[IDX_INNR] & ~mask);
    bankVal[0] = swapStrap ? xreg[IDX_WIN1] : xreg[IDX_WIN0];
    bankVal[1] = swapStrap ? xreg[IDX_WIN0] : xreg[IDX_WIN1];
    bankVal[2] = xreg[IDX_MODE][6] ? xreg[IDX_WIN2] : DATA_W'(8'hFE);
    bankVal[3] = DATA_W'(8'hFF);
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign winPage[w] = base | PAGE_W'(bankVal[w] & mask);
  end

  always_comb begin
    slot    = cpuAddr[OFF_W+SEL_W-1:OFF_W];
    effSlot = (xreg[IDX_CMD][6] && !slot[0]) ? {~slot[1], slot[0]} : slot;
    pageOut = winPage[effSlot];
  end

  assign physAddr = {pageOut, cpuAddr[OFF_W-1:0]};
  assign inWindow = cpuAddr[ADDR_W-1];

  assert_cmd_mid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cmdWe |=> xreg[IDX_CMD][5:3] == $past(xreg[IDX_CMD][5:3]));

  assert_bank_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.bankWe && !strobe.xregWe) |=>
      (($past(strobe.bankSel) ? xreg[IDX_WIN1] : xreg[IDX_WIN0]) == $past(cpuData)));

  assert_low_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inWindow |-> physAddr[OFF_W-1:0] == cpuAddr[OFF_W-1:0]);

  assert_last_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inWindow && slot == SEL_W'(NUM_WIN-1)) |->
      ((physAddr[OFF_W+DATA_W-1:OFF_W] & mask) == mask));
endmodule

// File: rtl/prg_page_mapper.sv
module prg_page_mapper
  import prg_map_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 12,
  parameter int OFF_W    = 13,
  parameter int NUM_XREG = 16,
  parameter int NUM_WIN  = 4,
  localparam int PHYS_W  = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              cpuWe,
  input  logic              swapStrap,
  output logic [PHYS_W-1:0] physAddr,
  output logic              inWindow
);
  wrStrobe_t  strobe;
  logic [2:0] cmdIdx;

  prg_map_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cmdIdx(cmdIdx), .strobe(strobe));

  prg_map_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .NUM_XREG(NUM_XREG), .NUM_WIN(NUM_WIN)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .swapStrap(swapStrap), .cmdIdx(cmdIdx),
    .physAddr(physAddr), .inWindow(inWindow));
endmodule

// File: tb/test_prg_page_mapper.sv
module test_prg_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0]  cpuData = 8'h00;
  logic        cpuWe = 1'b0;
  logic        swapStrap = 1'b0;
  logic [24:0] physAddr;
  logic        inWindow;
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;   // 250 MHz

  prg_page_mapper i_prg_page_mapper (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWe(cpuWe), .swapStrap(swapStrap), .physAddr(physAddr), .inWindow(inWindow));

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWe = 1'b1;
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic checkPage(input string req, input logic [15:0] a, input logic [11:0] expPage);
    logic [24:0] expAddr;
    cpuAddr = a;
    #1;
    expAddr = {expPage, a[12:0]};
    checks++;
    if (physAddr !== expAddr || inWindow !== 1'b1) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h/%b expected=%h/1", req, a, physAddr, inWindow, expAddr);
    end
  endtask

  task automatic checkFour(input string req, input logic [11:0] p0, input logic [11:0] p1,
                           input logic [11:0] p2, input logic [11:0] p3);
    checkPage(req, 16'h8000, p0);
    checkPage(req, 16'hA155, p1);
    checkPage(req, 16'hC0AA, p2);
    checkPage(req, 16'hFFFF, p3);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic testReset();      // R1, R10
    doReset();
    checkFour("R1", 12'h000, 12'h000, 12'h03E, 12'h03F);
    cpuAddr = 16'h7FFF;
    #1;
    checks++;
    if (inWindow !== 1'b0) begin
      errors++;
      $display("FAIL R10 inWindow at 7FFF actual=%b expected=0", inWindow);
    end
    checkPage("R10", 16'hE123, 12'h03F);
  endtask

  task automatic testWindows();    // R4, R9
    busWrite(16'h4107, 8'h05);
    busWrite(16'h4108, 8'h0A);
    busWrite(16'h4109, 8'h11);
    checkFour("R4", 12'h005, 12'h00A, 12'h03E, 12'h03F);
    busWrite(16'h410B, 8'h40);
    checkFour("R4", 12'h005, 12'h00A, 12'h011, 12'h03F);
  endtask

  task automatic testMaskBase();   // R2, R3
    busWrite(16'h410B, 8'h47);
    busWrite(16'h4107, 8'hC5);
    checkFour("R2", 12'h0C5, 12'h00A, 12'h011, 12'h0FF);
    busWrite(16'h410B, 8'h43);
    busWrite(16'h410A, 8'hF8);
    checkFour("R3", 12'h0FD, 12'h0FA, 12'h0F9, 12'h0FF);
    busWrite(16'h4100, 8'h3C);
    checkFour("R3", 12'h3FD, 12'h3FA, 12'h3F9, 12'h3FF);
    busWrite(16'h410B, 8'h46);
    checkFour("R2", 12'h3F8, 12'h3F8, 12'h3F8, 12'h3F8);
    busWrite(16'h410B, 8'h43);
  endtask

  task automatic testSwap();       // R5, R6
    busWrite(16'h9FFE, 8'h40);
    checkFour("R5", 12'h3F9, 12'h3FA, 12'h3FD, 12'h3FF);
    busWrite(16'h8000, 8'h06);
    checkFour("R6", 12'h3FD, 12'h3FA, 12'h3F9, 12'h3FF);
  endtask

  task automatic testBankData();   // R7
    busWrite(16'h8001, 8'h02);
    checkFour("R7", 12'h3FA, 12'h3FA, 12'h3F9, 12'h3FF);
    busWrite(16'h8000, 8'h07);
    busWrite(16'h9FFF, 8'h04);
    checkFour("R7", 12'h3FA, 12'h3FC, 12'h3F9, 12'h3FF);
    busWrite(16'h8000, 8'h02);
    busWrite(16'h8001, 8'h07);
    busWrite(16'hA001, 8'h55);
    busWrite(16'hE000, 8'h55);
    busWrite(16'hC001, 8'h55);
    checkFour("R7", 12'h3FA, 12'h3FC, 12'h3F9, 12'h3FF);
  endtask

  task automatic testDecodeEdge(); // R9
    busWrite(16'h4110, 8'h00);
    busWrite(16'h4117, 8'h00);
    busWrite(16'h4007, 8'h00);
    busWrite(16'h410F, 8'hAA);
    checkFour("R9", 12'h3FA, 12'h3FC, 12'h3F9, 12'h3FF);
  endtask

  task automatic testStrap();      // R8
    swapStrap = 1'b1;
    checkFour("R8", 12'h3FC, 12'h3FA, 12'h3F9, 12'h3FF);
    swapStrap = 1'b0;
    checkFour("R8", 12'h3FA, 12'h3FC, 12'h3F9, 12'h3FF);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testWindows();
    testMaskBase();
    testSwap();
    testBankData();
    testDecodeEdge();
    testStrap();
    testReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule